// File: doc/BRIEF.md
# ADC Conversion Start and Status Controller

This block is the digital control shell around a successive-approximation converter. It chooses one of four start sources through a two-bit mode input. The sources are a one-cycle software start pulse, an overflow pulse from timer A, a rising edge on an asynchronous external start pin, and an overflow pulse from timer B. Once a conversion is accepted, the block keeps a busy flag high for a fixed number of conversion-clock periods. The conversion clock is the system clock divided down by a programmable ratio.

When busy drops, the block latches the 12-bit converter code into a 16-bit high/low register pair. It places the code left or right justified, as a control bit selects. It then sets a completion flag, and it raises an interrupt when interrupts are enabled. Software clears the flag by a clear pulse. Starts are spaced so that the rate never exceeds 100 thousand conversions per second. The converter itself is modelled by a data input that the block samples at the end of each conversion.

The result pair is a register that holds its value until the next conversion ends. It is not a stream, so it has no handshake.

Top module: `adc_start_ctrl`

## Requirements
- R1: With mode 00, a one-cycle `sw_start_i` pulse starts a conversion, and `busy_o` reads 1 in the cycle after the pulse.
- R2: With mode 01, a `tmra_ovf_i` pulse starts a conversion in the next cycle. `sw_start_i`, `tmrb_ovf_i` and edges on `ext_start_i` start nothing while mode 01 is selected.
- R3: With mode 10, a rising edge on `ext_start_i` starts a conversion. The pin passes through two synchronizer flops and one edge flop, so `busy_o` reads 1 three cycles after the pin rises. A level that stays high starts only one conversion.
- R4: With mode 11, a `tmrb_ovf_i` pulse starts a conversion in the next cycle.
- R5: `busy_o` stays high for exactly 16 × (`div_i` + 1) system-clock cycles.
- R6: A trigger that arrives while `busy_o` is 1 is dropped. It neither lengthens the conversion nor starts a later one.
- R7: `done_flag_o` becomes 1 one cycle after `busy_o` falls. `irq_o` is 1 exactly when `done_flag_o` and `irq_en_i` are both 1.
- R8: A `flag_clr_i` pulse clears `done_flag_o`. If a hardware set and a clear fall in the same cycle, the set wins.
- R9: When busy falls, the 12-bit `sar_data_i` code is latched into the 16-bit word {`res_hi_o`,`res_lo_o`}. With `ljust_i` = 0 the code sits in bits [11:0] and the top four bits are zero. With `ljust_i` = 1 the code sits in bits [15:4] and the low four bits are zero. The word does not change at any other time.
- R10: Two accepted starts are never closer than `CLK_HZ`/100000 system-clock cycles. A trigger that is held waits for that spacing.
- R11: After reset, `busy_o`, `done_flag_o`, `irq_o`, `res_hi_o` and `res_lo_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Start source: 00 software, 01 timer A, 10 external edge, 11 timer B |
| div_i | input | DIV_W | Conversion-clock divider; ratio is value + 1 |
| ljust_i | input | 1 | 1 = left-justified result, 0 = right-justified |
| irq_en_i | input | 1 | Interrupt enable |
| sw_start_i | input | 1 | Software start pulse (a write of 1 to busy) |
| tmra_ovf_i | input | 1 | Timer A overflow pulse |
| tmrb_ovf_i | input | 1 | Timer B overflow pulse |
| ext_start_i | input | 1 | Asynchronous external convert-start pin |
| flag_clr_i | input | 1 | Software clear of the completion flag |
| sar_data_i | input | RES_W | Converter code, sampled when the conversion ends |
| busy_o | output | 1 | Conversion in progress |
| done_flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt request |
| res_hi_o | output | 8 | High byte of the justified result |
| res_lo_o | output | 8 | Low byte of the justified result |

## Verification
The assertions assume that `div_i`, `ljust_i`, `mode_i` and `sar_data_i` hold steady while `busy_o` is 1. They also assume that software start and timer pulses last one cycle, and that the clear input is not held across a completion except where a test checks set-over-clear priority. The stimulus changes configuration only while the block is idle and the start spacing has run out. Data is driven on the falling clock edge, so the block sees each value for a full cycle. The external pin is the only input that enters through the synchronizer, so it is the only one that may change without regard to the clock.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [1:0] {
    SRC_SW   = 2'b00,
    SRC_TMRA = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_TMRB = 2'b11
  } start_src_e;

  localparam int unsigned WORD_W = 16;

  // Place a RES_W-bit code inside a WORD_W-bit word, at the top or at the bottom.
  function automatic logic [WORD_W-1:0] place_code(input logic [WORD_W-1:0] code,
                                                   input int unsigned res_w,
                                                   input logic to_top);
    logic [WORD_W-1:0] w;
    w = code;
    if (to_top) w = code << (WORD_W - res_w);
    return w;
  endfunction

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R3: one edge yields a single-cycle pulse, never two in a row
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R5: the prescaler starts each conversion from zero
  p_div_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int unsigned TICKS = 16,
  parameter int unsigned GAP   = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic tick_i,
  output logic busy_o,
  output logic end_o
);
  localparam int unsigned GAP_C = (GAP < 1) ? 1 : GAP;
  localparam int unsigned GW    = $clog2(GAP_C + 1);
  localparam int unsigned TW    = $clog2(TICKS);

  logic          busy_q;
  logic [TW-1:0] tick_cnt_q;
  logic [GW-1:0] gap_q;
  logic          start;

  assign start  = trig_i && !busy_q && (gap_q == '0);
  assign end_o  = busy_q && tick_i && (tick_cnt_q == TW'(TICKS-1));
  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      tick_cnt_q <= '0;
      gap_q      <= '0;
    end else begin
      if (start)              gap_q <= GW'(GAP_C - 1);
      else if (gap_q != '0)   gap_q <= gap_q - 1'b1;

      if (start) begin
        busy_q     <= 1'b1;
        tick_cnt_q <= '0;
      end else if (end_o) begin
        busy_q     <= 1'b0;
        tick_cnt_q <= '0;
      end else if (busy_q && tick_i) begin
        tick_cnt_q <= tick_cnt_q + 1'b1;
      end
    end
  end

  // Checker counter: cycles since the last accepted start, saturating
  logic [GW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                  since_q <= GW'(GAP_C);
    else if (start)              since_q <= GW'(1);
    else if (since_q < GW'(GAP_C)) since_q <= since_q + 1'b1;
  end

  p_start_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (since_q >= GW'(GAP_C)));

  // R6: a trigger during a conversion does not cut it short
  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !end_o) |=> busy_q);
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter int unsigned RATE_HZ = 100_000,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned RES_W   = 12,
  parameter int unsigned TICKS   = 16,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ljust_i,
  input  logic             irq_en_i,
  input  logic             sw_start_i,
  input  logic             tmra_ovf_i,
  input  logic             tmrb_ovf_i,
  input  logic             ext_start_i,
  input  logic             flag_clr_i,
  input  logic [RES_W-1:0] sar_data_i,
  output logic             busy_o,
  output logic             done_flag_o,
  output logic             irq_o,
  output logic [7:0]       res_hi_o,
  output logic [7:0]       res_lo_o
);
  localparam int unsigned GAP = CLK_HZ / RATE_HZ;

  logic             ext_rise, trig, tick, conv_end, busy, busy_d1, fell;
  logic             flag_q;
  logic [WORD_W-1:0] word_q;

  adc_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_start_i), .rise_o(ext_rise));

  always_comb begin
    unique case (start_src_e'(mode_i))
      SRC_SW:   trig = sw_start_i;
      SRC_TMRA: trig = tmra_ovf_i;
      SRC_EXT:  trig = ext_rise;
      SRC_TMRB: trig = tmrb_ovf_i;
      default:  trig = 1'b0;
    endcase
  end

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(busy), .div_i(div_i), .tick_o(tick));

  adc_conv_seq #(.TICKS(TICKS), .GAP(GAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .tick_i(tick),
    .busy_o(busy), .end_o(conv_end));

  assign fell = busy_d1 & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_d1 <= 1'b0;
      flag_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      busy_d1 <= busy;
      if (fell)            flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      if (conv_end)
        word_q <= place_code(WORD_W'(sar_data_i), RES_W, ljust_i);
    end
  end

  assign busy_o      = busy;
  assign done_flag_o = flag_q;
  assign irq_o       = flag_q & irq_en_i;
  assign res_hi_o    = word_q[15:8];
  assign res_lo_o    = word_q[7:0];

  p_flag_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |=> done_flag_o);

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done_flag_o);

  p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fell && flag_clr_i) |=> done_flag_o);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_o) |-> $stable({res_hi_o, res_lo_o}));
endmodule

// File: tb/tb_adc_start_ctrl.sv
module tb_adc_start_ctrl;
  localparam int unsigned CLK_HZ = 125_000_000;
  localparam int unsigned GAP    = CLK_HZ / 100_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] div = 8'd0;
  logic       ljust = 1'b0, irq_en = 1'b0;
  logic       sw = 1'b0, ta = 1'b0, tb = 1'b0, ext = 1'b0, clr = 1'b0;
  logic [11:0] sar = 12'h000;
  logic       busy, flag, irq;
  logic [7:0] hi, lo;

  always #4 clk = ~clk;

  adc_start_ctrl #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .div_i(div), .ljust_i(ljust),
    .irq_en_i(irq_en), .sw_start_i(sw), .tmra_ovf_i(ta), .tmrb_ovf_i(tb),
    .ext_start_i(ext), .flag_clr_i(clr), .sar_data_i(sar),
    .busy_o(busy), .done_flag_o(flag), .irq_o(irq), .res_hi_o(hi), .res_lo_o(lo));

  typedef struct { logic [15:0] word; int len; } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0, n_rise = 0, cyc = 0, rise_t0 = 0, rise_t1 = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // Monitor: measures each busy window and compares the latched word
  logic prev_busy = 1'b0;
  int   blen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        n_rise++; rise_t0 = rise_t1; rise_t1 = cyc;
      end
      if (busy) blen++;
      if (prev_busy && !busy) begin
        if (q.size() == 0) chk("R6 unexpected conversion", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk("R5 busy length", blen, e.len);
          chk("R9 result word", int'({hi, lo}), int'(e.word));
        end
        blen = 0;
      end
      prev_busy = busy;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_conv(input logic [11:0] d, input logic lj, input int dv);
    exp_t e;
    e.word = lj ? {d, 4'h0} : {4'h0, d};
    e.len  = 16 * (dv + 1);
    q.push_back(e);
  endtask

  // Driver: configure, push expectation, fire one trigger, check start latency
  task automatic run_conv(input logic [1:0] src, input logic [11:0] d,
                          input logic lj, input int dv);
    @(negedge clk);
    mode = src; div = 8'(dv); ljust = lj; sar = d;
    expect_conv(d, lj, dv);
    @(negedge clk);
    case (src)
      2'b00: sw = 1'b1;
      2'b01: ta = 1'b1;
      2'b10: ext = 1'b1;
      default: tb = 1'b1;
    endcase
    @(negedge clk);
    sw = 1'b0; ta = 1'b0; tb = 1'b0; ext = 1'b0;
    if (src == 2'b10) begin
      @(negedge clk); chk("R3 not yet started", int'(busy), 0);
      @(negedge clk); chk("R3 start after sync", int'(busy), 1);
    end else if (src == 2'b00) chk("R1 start latency", int'(busy), 1);
    else if (src == 2'b01)     chk("R2 start latency", int'(busy), 1);
    else                       chk("R4 start latency", int'(busy), 1);
    idle(16 * (dv + 1) + 4);
    chk("R7 flag after end", int'(flag), 1);
    chk("R7 irq gating", int'(irq), int'(irq_en));
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R8 clear", int'(flag), 0);
    idle(GAP);
  endtask

  initial begin
    idle(3);
    chk("R11 busy reset", int'(busy), 0);
    chk("R11 flag reset", int'(flag), 0);
    chk("R11 irq reset", int'(irq), 0);
    chk("R11 result reset", int'({hi, lo}), 0);
    rst_n = 1'b1;
    idle(2);

    run_conv(2'b00, 12'hA5C, 1'b0, 0);          // R1, R9 right
    irq_en = 1'b1;
    run_conv(2'b01, 12'h3F1, 1'b1, 1);          // R2, R9 left, R5 div 1
    run_conv(2'b11, 12'hFFF, 1'b0, 3);          // R4, R5 div 3
    run_conv(2'b10, 12'h801, 1'b1, 0);          // R3

    // R2: other sources ignored in timer-A mode
    mode = 2'b01; sw = 1'b1; tb = 1'b1; ext = 1'b1;
    @(negedge clk); sw = 1'b0; tb = 1'b0;
    idle(6); ext = 1'b0;
    chk("R2 other sources ignored", int'(busy), 0);
    idle(4);

    // R6: trigger mid-conversion dropped
    @(negedge clk); mode = 2'b00; div = 8'd1; ljust = 1'b0; sar = 12'h123;
    expect_conv(12'h123, 1'b0, 1);
    sw = 1'b1; @(negedge clk); sw = 1'b0;
    idle(10); sw = 1'b1; @(negedge clk); sw = 1'b0;
    idle(40);
    begin
      int seen = 0;
      for (int i = 0; i < GAP + 20; i++) begin
        @(negedge clk); if (busy) seen++;
      end
      chk("R6 no deferred start", seen, 0);
    end
    clr = 1'b1; @(negedge clk); clr = 1'b0;

    // R3: level held high starts only once
    begin
      int r0;
      @(negedge clk); mode = 2'b10; div = 8'd0; sar = 12'h0F0;
      expect_conv(12'h0F0, 1'b0, 0);
      r0 = n_rise;
      ext = 1'b1;
      idle(2 * GAP + 50);
      chk("R3 held level one start", n_rise - r0, 1);
      ext = 1'b0; idle(4);
      clr = 1'b1; @(negedge clk); clr = 1'b0;
    end

    // R10: held software trigger is spaced
    begin
      int r0;
      @(negedge clk); mode = 2'b00; sar = 12'h5A5;
      expect_conv(12'h5A5, 1'b0, 0);
      expect_conv(12'h5A5, 1'b0, 0);
      r0 = n_rise;
      sw = 1'b1;
      idle(GAP + 40);
      sw = 1'b0;
      chk("R10 starts in window", n_rise - r0, 2);
      chk("R10 spacing", rise_t1 - rise_t0, GAP);
      idle(GAP);
    end

    // R8: set wins over a same-cycle clear
    clr = 1'b1; @(negedge clk);
    chk("R8 flag cleared", int'(flag), 0);
    sar = 12'h777; ljust = 1'b1;
    expect_conv(12'h777, 1'b1, 0);
    sw = 1'b1; @(negedge clk); sw = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk); clr = 1'b0;
    chk("R8 set beats clear", int'(flag), 1);
    irq_en = 1'b0; #1;
    chk("R7 irq off when disabled", int'(irq), 0);
    idle(4);
    chk("R9 all results seen", q.size(), 0);
    done = 1;
  end

  initial begin
    int w = 0;
    while (!done && w < 150_000) begin @(posedge clk); w++; end
    if (!done) chk("watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule